// File: doc/BRIEF.md
# Host Port Ready Controller

This block is the control side of a 16-bit multiplexed host port. An external host uses it to reach a 32-bit internal memory space through three registers: control, address and data. Each register is 32 bits wide and is moved as two 16-bit halves. The block works out the internal access strobe from the chip-select and two data strobes. A host access ends on the clock after the strobe goes inactive, and its effect takes hold on that clock.

Host writes to the data register are collected into a write queue that drains toward a request/acknowledge memory port. Host reads of the data register come either from a read-ahead queue, which follows the address register, or from a single fresh fetch. The block drives a not-ready flag back to the host. That flag is decided case by case from the register being accessed, the half, the auto-increment choice, any pending prefetch, and the state of both queues.

The host picks the register with a 2-bit selector: 0 control, 1 address, 2 data with auto-increment, 3 data without increment. A half select of 0 means bits 15:0 and 1 means bits 31:16.

Top module: `hostport_rdy_ctl`

## Requirements
- R1: An access is active only while `hcs_n` is low and `hds1_n` differs from `hds2_n`. Strobe levels that are equal, or a high `hcs_n`, leave every register unchanged.
- R2: While `hcs_n` is high, `hrdy_n` is low (ready). This also holds when it interrupts an access that was not ready.
- R3: Reads of the control register (select 0) and the address register (select 1) are ready on both halves and return the stored 32-bit value, half 0 giving bits 15:0. Control writes are always ready.
- R4: After an address-register write completes, a further address-register write is not ready for `ADDR_GAP` (default 4) clocks. This applies on either half. An address write after a long idle time is ready at once.
- R5: An address-register write is not ready while the write queue holds data. When it becomes ready, all queued words have been written to memory at the addresses they were queued with.
- R6: A control write to half 0 with bit 0 set starts a prefetch. A following address-register write is not ready until the first prefetched word has returned from memory.
- R7: A data write is not ready when the write queue holds `DEPTH` (default 8) words, or when a flush is in progress. A flush starts with a control write to half 0 with bit 1 set while the queue is not empty, and ends when the queue empties. With select 2 this applies on both halves; with select 3 only half 1 can be not ready.
- R8: Completing half 1 of a data write queues the word {half 1, half 0} for the current address. Select 2 then adds 4 to the address register; select 3 leaves it unchanged.
- R9: A select-2 read is not ready on half 0 only while the read-ahead queue is empty. Half 1 is always ready. The reads return consecutive words from the address register onward, and each completed half 1 adds 4 to the address register.
- R10: A select-3 read is not ready on half 0 until a fresh word has been fetched from the current address. Half 1 is ready, and the address register does not change.
- R11: Once a memory request is raised, it stays raised with stable address and direction until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcs_n | input | 1 | Host chip-select, active low |
| hds1_n | input | 1 | Host data strobe 1 |
| hds2_n | input | 1 | Host data strobe 2 |
| hrw | input | 1 | 1 = host read, 0 = host write |
| hsel | input | 2 | Register select: 0 control, 1 address, 2 data auto-increment, 3 data fixed |
| hhalf | input | 1 | Half select: 0 bits 15:0, 1 bits 31:16 |
| hdin | input | 16 | Host write data |
| hdout | output | 16 | Host read data |
| hrdy_n | output | 1 | High means not ready |
| mreq | output | 1 | Memory request |
| mwe | output | 1 | Memory request is a write |
| maddr | output | 32 | Memory byte address |
| mwdata | output | 32 | Memory write data |
| mack | input | 1 | Memory acknowledge, one-clock pulse |
| mrdata | input | 32 | Memory read data, valid with `mack` |

## Verification
The queue-overflow, drain-before-address and fresh-fetch properties hold only if the host obeys the handshake. The host keeps select, direction, half and data stable from strobe assertion until one clock after strobe release. It also releases a strobe only after it has seen `hrdy_n` low. The one exception is dropping chip-select on an auto-increment read; that abort is harmless because committing half 0 of such a read changes nothing. The bench host task follows this protocol for every access, so the random address, data and memory latency in the stimulus never break these assumptions. The memory model acknowledges each request exactly once, after a latency of at least one clock.

// File: rtl/hostport_rdy_ctl.sv
module hostport_rdy_ctl #(
  parameter int DEPTH    = 8,
  parameter int ADDR_GAP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hcs_n,
  input  logic        hds1_n,
  input  logic        hds2_n,
  input  logic        hrw,
  input  logic [1:0]  hsel,
  input  logic        hhalf,
  input  logic [15:0] hdin,
  output logic [15:0] hdout,
  output logic        hrdy_n,
  output logic        mreq,
  output logic        mwe,
  output logic [31:0] maddr,
  output logic [31:0] mwdata,
  input  logic        mack,
  input  logic [31:0] mrdata
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int GW = $clog2(ADDR_GAP + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  typedef enum logic [1:0] {K_WR, K_FIX, K_PF} kind_t;

  logic          strb, strb_q, commit, c_wr, c_rd, rd_acc, nr;
  logic [31:0]   haddr, haddr_nx, faddr, ctl, fix_word, src;
  logic [15:0]   wlo;
  logic [63:0]   wf_mem [DEPTH];
  logic [31:0]   rf_mem [DEPTH];
  logic [PW-1:0] wf_wp, wf_rp, rf_wp, rf_rp;
  logic [CW-1:0] wf_cnt, rf_cnt;
  logic [GW-1:0] gap;
  logic          rf_run, pf_pend, flushing, fix_valid, drop;
  kind_t         kind;

  assign strb   = !hcs_n && (hds1_n ^ hds2_n);
  assign commit = strb_q && !strb;
  assign c_wr   = commit && !hrw;
  assign c_rd   = commit && hrw;
  assign rd_acc = strb && hrw;

  wire wf_full  = (wf_cnt == FULL);
  wire wf_empty = (wf_cnt == '0);
  wire rf_empty = (rf_cnt == '0);
  wire a_wr     = c_wr && hsel == 2'd1;
  wire pf_cmd   = c_wr && hsel == 2'd0 && !hhalf && hdin[0];
  wire fl_cmd   = c_wr && hsel == 2'd0 && !hhalf && hdin[1];
  wire wf_push  = c_wr && hsel[1] && hhalf;
  wire rf_pop   = c_rd && hsel == 2'd2 && hhalf;
  wire wf_pop   = mreq && mack && kind == K_WR;
  wire pf_land  = mreq && mack && kind == K_PF && !drop;
  wire rf_clr   = a_wr || wf_push || pf_cmd;
  wire iss_wr   = !mreq && !wf_empty;
  wire iss_fix  = !mreq && wf_empty && rd_acc && hsel == 2'd3 && !hhalf && !fix_valid;
  wire iss_pf   = !mreq && wf_empty && !iss_fix && rf_run && !rf_clr && rf_cnt < FULL;

  always_comb begin
    unique case (hsel)
      2'd0: nr = 1'b0;
      2'd1: nr = !hrw && (gap != '0 || !wf_empty || pf_pend);
      2'd2: nr = hrw ? (!hhalf && rf_empty) : (wf_full || flushing);
      default: nr = hrw ? (!hhalf && !fix_valid) : (hhalf && (wf_full || flushing));
    endcase
  end
  assign hrdy_n = strb && nr;

  always_comb begin
    unique case (hsel)
      2'd0:    src = ctl;
      2'd1:    src = haddr;
      2'd2:    src = rf_mem[rf_rp];
      default: src = fix_word;
    endcase
  end
  assign hdout = hhalf ? src[31:16] : src[15:0];

  always_comb begin
    haddr_nx = haddr;
    if (a_wr) begin
      if (hhalf) haddr_nx[31:16] = hdin;
      else       haddr_nx[15:0]  = hdin;
    end else if ((wf_push && hsel == 2'd2) || rf_pop) begin
      haddr_nx = haddr + 32'd4;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q <= 1'b0; haddr <= '0; faddr <= '0; ctl <= '0; wlo <= '0;
      gap <= '0; wf_wp <= '0; wf_rp <= '0; wf_cnt <= '0;
      rf_wp <= '0; rf_rp <= '0; rf_cnt <= '0; rf_run <= 1'b0; pf_pend <= 1'b0;
      flushing <= 1'b0; fix_valid <= 1'b0; fix_word <= '0; drop <= 1'b0;
      mreq <= 1'b0; mwe <= 1'b0; maddr <= '0; mwdata <= '0; kind <= K_WR;
    end else begin
      strb_q <= strb;
      haddr  <= haddr_nx;
      if (a_wr)            gap <= GW'(ADDR_GAP);
      else if (gap != '0)  gap <= gap - 1'b1;
      if (c_wr && hsel == 2'd0) begin
        if (hhalf) ctl[31:16] <= hdin;
        else       ctl[15:0]  <= hdin;
      end
      if (c_wr && hsel[1] && !hhalf) wlo <= hdin;

      if (wf_push) begin
        wf_mem[wf_wp] <= {haddr, hdin, wlo};
        wf_wp <= wf_wp + 1'b1;
      end
      if (wf_pop) wf_rp <= wf_rp + 1'b1;
      if (wf_push && !wf_pop)      wf_cnt <= wf_cnt + 1'b1;
      else if (!wf_push && wf_pop) wf_cnt <= wf_cnt - 1'b1;
      flushing <= (fl_cmd && !wf_empty) ? 1'b1 : (wf_empty ? 1'b0 : flushing);

      if (rf_clr) begin
        rf_wp <= '0; rf_rp <= '0; rf_cnt <= '0;
        rf_run <= pf_cmd; pf_pend <= pf_cmd; faddr <= haddr_nx;
        drop <= mreq && !mack && kind == K_PF;
      end else begin
        if (pf_land) begin
          rf_mem[rf_wp] <= mrdata;
          rf_wp <= rf_wp + 1'b1;
          pf_pend <= 1'b0;
        end
        if (rf_pop) rf_rp <= rf_rp + 1'b1;
        if (pf_land && !rf_pop)      rf_cnt <= rf_cnt + 1'b1;
        else if (!pf_land && rf_pop) rf_cnt <= rf_cnt - 1'b1;
        if (rd_acc && hsel == 2'd2) rf_run <= 1'b1;
        if (iss_pf) faddr <= faddr + 32'd4;
        if (mreq && mack) drop <= 1'b0;
      end

      if (mreq && mack && kind == K_FIX) begin
        fix_valid <= 1'b1;
        fix_word  <= mrdata;
      end else if (c_wr || (c_rd && hsel == 2'd3 && hhalf)) begin
        fix_valid <= 1'b0;
      end

      if (mreq) begin
        if (mack) mreq <= 1'b0;
      end else if (iss_wr || iss_fix || iss_pf) begin
        mreq <= 1'b1;
        mwe  <= iss_wr;
        kind <= iss_wr ? K_WR : (iss_fix ? K_FIX : K_PF);
        maddr  <= iss_wr ? wf_mem[wf_rp][63:32] : (iss_fix ? haddr : faddr);
        mwdata <= wf_mem[wf_rp][31:0];
      end
    end
  end

  AST_WQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wf_push |-> (!wf_full || wf_pop)); // R7
  AST_RQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pf_land |-> (rf_cnt < FULL)); // R9
  AST_ADDR_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr |-> wf_empty); // R5
  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wf_push && hsel == 2'd2) |=> (haddr == $past(haddr) + 32'd4)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq && !mack) |=> (mreq && $stable(maddr) && $stable(mwe))); // R11
  AST_FRESH_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(strb) && hrw && hsel == 2'd3 && !hhalf) |-> hrdy_n); // R10
endmodule

// File: tb/test_hostport_rdy_ctl.sv
module test_hostport_rdy_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hcs_n = 1'b1, hds1_n = 1'b1, hds2_n = 1'b1, hrw = 1'b0, hhalf = 1'b0;
  logic [1:0] hsel = 2'd0;
  logic [15:0] hdin = '0, hdout;
  logic hrdy_n, mreq, mwe, mack;
  logic [31:0] maddr, mwdata, mrdata;

  hostport_rdy_ctl i_hostport_rdy_ctl (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, lat = 2, mcnt = 0, r11_bad = 0;
  logic [31:0] mem [256];
  logic [31:0] shadow [256];
  logic p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0;

  function automatic logic [31:0] seed_word(int i);
    return (i * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  always @(posedge clk) begin
    mack <= 1'b0;
    if (rst_n && mreq && !mack) begin
      if (mcnt >= lat) begin
        mack   <= 1'b1;
        mrdata <= mem[maddr[9:2]];
        if (mwe) mem[maddr[9:2]] <= mwdata;
        mcnt <= 0;
      end else mcnt <= mcnt + 1;
    end
  end

  always @(posedge clk) begin
    if (rst_n && p_req && !p_ack && (!mreq || maddr != p_addr || mwe != p_we)) r11_bad <= r11_bad + 1;
    p_req <= mreq; p_ack <= mack; p_addr <= maddr; p_we <= mwe;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic rw, input logic [1:0] sel, input logic half,
                     input logic [15:0] din, output logic [15:0] dout, output int waits);
    @(negedge clk);
    hrw = rw; hsel = sel; hhalf = half; hdin = din;
    hcs_n = 1'b0; hds1_n = 1'b0; hds2_n = 1'b1; waits = 0;
    #1;
    while (hrdy_n) begin @(negedge clk); #1; waits++; end
    dout = hdout;
    @(negedge clk); hds2_n = 1'b0;
    @(negedge clk); hcs_n = 1'b1; hds1_n = 1'b1; hds2_n = 1'b1;
  endtask

  task automatic wr32(input logic [1:0] sel, input logic [31:0] v, output int w0, output int w1);
    logic [15:0] d;
    acc(1'b0, sel, 1'b0, v[15:0], d, w0);
    acc(1'b0, sel, 1'b1, v[31:16], d, w1);
  endtask

  task automatic rd32(input logic [1:0] sel, output logic [31:0] v, output int w0, output int w1);
    logic [15:0] lo, hi;
    acc(1'b1, sel, 1'b0, 16'h0, lo, w0);
    acc(1'b1, sel, 1'b1, 16'h0, hi, w1);
    v = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    chk(r11_bad == 0, "R11 request stability", r11_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, a;
    logic [15:0] d;
    int w0, w1, w;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) begin mem[i] = seed_word(i); shadow[i] = seed_word(i); end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(hrdy_n == 1'b0, "R2 ready after reset", hrdy_n, 0);
    chk(mreq == 1'b0, "R11 no request after reset", mreq, 0);

    rd32(2'd1, v, w0, w1);
    chk(v == 32'h0 && w0 == 0 && w1 == 0, "R3 address reset read", v, 0);
    wr32(2'd1, 32'h0000_0040, w0, w1);
    chk(w0 == 0, "R4 idle address write ready", w0, 0);
    chk(w1 > 0, "R4 back-to-back address write waits", w1, 1);
    rd32(2'd1, v, w0, w1);
    chk(v == 32'h40 && w0 == 0 && w1 == 0, "R3 address read back", v, 32'h40);
    wr32(2'd0, 32'h1234_5670, w0, w1);
    chk(w0 == 0 && w1 == 0, "R3 control write ready", w0 + w1, 0);
    rd32(2'd0, v, w0, w1);
    chk(v == 32'h1234_5670 && w0 + w1 == 0, "R3 control read back", v, 32'h1234_5670);

    // R1: equal strobes and chip-select high produce no access
    @(negedge clk);
    hrw = 1'b0; hsel = 2'd1; hhalf = 1'b0; hdin = 16'hFFFF;
    hcs_n = 1'b0; hds1_n = 1'b0; hds2_n = 1'b0;
    idle(3); #1;
    chk(hrdy_n == 1'b0, "R1 equal strobes idle", hrdy_n, 0);
    hcs_n = 1'b1; hds2_n = 1'b1;
    idle(3);
    hds1_n = 1'b1;
    idle(8);
    rd32(2'd1, v, w0, w1);
    chk(v == 32'h40, "R1 address unchanged", v, 32'h40);

    rd32(2'd2, v, w0, w1);
    chk(w0 > 0, "R9 empty queue first half waits", w0, 1);
    chk(w1 == 0, "R9 second half ready", w1, 0);
    chk(v == shadow[8'h10], "R9 first word", v, shadow[8'h10]);
    idle(30);
    rd32(2'd2, v, w0, w1);
    chk(w0 == 0, "R9 queued word ready", w0, 0);
    chk(v == shadow[8'h11], "R9 second word", v, shadow[8'h11]);
    rd32(2'd1, v, w0, w1);
    chk(v == 32'h48, "R9 address advanced", v, 32'h48);

    idle(10);
    wr32(2'd1, 32'h80, w0, w1);
    rd32(2'd3, v, w0, w1);
    chk(w0 > 0 && w1 == 0, "R10 fresh fetch waits on half 0 only", w0, 1);
    chk(v == shadow[8'h20], "R10 fixed read data", v, shadow[8'h20]);
    rd32(2'd3, v, w0, w1);
    chk(w0 > 0, "R10 repeated fixed read waits again", w0, 1);
    rd32(2'd1, v, w0, w1);
    chk(v == 32'h80, "R10 address not advanced", v, 32'h80);

    idle(10);
    wr32(2'd1, 32'h100, w0, w1);
    wr32(2'd2, 32'h1111_2222, w0, w1); shadow[8'h40] = 32'h1111_2222;
    rd32(2'd1, v, w0, w1);
    chk(v == 32'h104, "R8 auto write advances address", v, 32'h104);
    wr32(2'd3, 32'h3333_4444, w0, w1); shadow[8'h41] = 32'h3333_4444;
    rd32(2'd1, v, w0, w1);
    chk(v == 32'h104, "R8 fixed write keeps address", v, 32'h104);
    idle(10);
    wr32(2'd1, 32'h200, w0, w1);
    chk(mem[8'h40] == 32'h1111_2222, "R8 auto word in memory", mem[8'h40], 32'h1111_2222);
    chk(mem[8'h41] == 32'h3333_4444, "R8 fixed word in memory", mem[8'h41], 32'h3333_4444);

    // R5: drain before the address changes
    lat = 40;
    idle(10);
    wr32(2'd1, 32'h180, w0, w1);
    for (int i = 0; i < 3; i++) begin
      wr32(2'd2, 32'hA000_0000 + i, w0, w1); shadow[8'h60 + i] = 32'hA000_0000 + i;
    end
    acc(1'b0, 2'd1, 1'b0, 16'h0200, d, w);
    chk(w > 0, "R5 address write waits for drain", w, 1);
    chk(mem[8'h62] == 32'hA000_0002, "R5 last queued word written", mem[8'h62], 32'hA000_0002);
    acc(1'b0, 2'd1, 1'b1, 16'h0000, d, w);

    // R6: prefetch command blocks the next address write
    lat = 30;
    idle(10);
    acc(1'b0, 2'd0, 1'b0, 16'h0001, d, w);
    chk(w == 0, "R3 prefetch command write ready", w, 0);
    acc(1'b0, 2'd1, 1'b0, 16'h0300, d, w);
    chk(w >= 20, "R6 address write waits for prefetch", w, 20);
    acc(1'b0, 2'd1, 1'b1, 16'h0000, d, w);

    // R7: flush in progress
    lat = 100;
    idle(10);
    wr32(2'd2, 32'hB000_0000, w0, w1); shadow[8'hC0] = 32'hB000_0000;
    acc(1'b0, 2'd0, 1'b0, 16'h0002, d, w);
    chk(w == 0, "R7 flush command ready", w, 0);
    wr32(2'd2, 32'hB000_0001, w0, w1); shadow[8'hC1] = 32'hB000_0001;
    chk(w0 >= 50, "R7 data write waits during flush", w0, 50);

    // R7: full queue
    lat = 300;
    idle(5);
    for (int i = 0; i < 8; i++) begin
      wr32(2'd2, 32'hC000_0000 + i, w0, w1); shadow[8'hC2 + i] = 32'hC000_0000 + i;
    end
    acc(1'b0, 2'd3, 1'b0, 16'h5555, d, w);
    chk(w == 0, "R7 fixed write half 0 ready when full", w, 0);
    acc(1'b0, 2'd3, 1'b1, 16'h6666, d, w); shadow[8'hCA] = 32'h6666_5555;
    chk(w > 0, "R7 fixed write half 1 waits when full", w, 1);
    lat = 2;
    wr32(2'd1, 32'h0, w0, w1);
    for (int i = 0; i < 11; i++)
      chk(mem[8'hC0 + i] == shadow[8'hC0 + i], "R8 queued words landed", mem[8'hC0 + i], shadow[8'hC0 + i]);

    // R2: chip-select release forces ready
    lat = 20;
    idle(10);
    wr32(2'd1, 32'h40, w0, w1);
    @(negedge clk);
    hrw = 1'b1; hsel = 2'd2; hhalf = 1'b0; hcs_n = 1'b0; hds1_n = 1'b0; hds2_n = 1'b1;
    @(negedge clk); #1;
    chk(hrdy_n == 1'b1, "R9 empty queue not ready", hrdy_n, 1);
    hcs_n = 1'b1; #1;
    chk(hrdy_n == 1'b0, "R2 chip-select high forces ready", hrdy_n, 0);
    @(negedge clk); hds1_n = 1'b1; hds2_n = 1'b1;
    idle(40);

    for (int n = 0; n < 30; n++) begin
      int op;
      logic [7:0] ix;
      op = $urandom_range(2, 0);
      ix = 8'($urandom_range(255, 0));
      lat = $urandom_range(6, 1);
      idle(6);
      wr32(2'd1, {22'h0, ix, 2'b00}, w0, w1);
      if (op == 0) begin
        a = $urandom;
        wr32(2'd2, a, w0, w1); shadow[ix] = a;
      end else if (op == 1) begin
        rd32(2'd3, v, w0, w1);
        chk(v == shadow[ix] && w0 > 0, "R10 random fixed read", v, shadow[ix]);
      end else begin
        rd32(2'd2, v, w0, w1);
        chk(v == shadow[ix] && w1 == 0, "R9 random auto read", v, shadow[ix]);
      end
    end
    idle(10);
    finish_run();
  end
endmodule